// File: doc/BRIEF.md
# RNG Interrupt and Fault Status

This block holds the sticky completion and fault flags of a random-number core and turns them into one level-sensitive interrupt line. Three flags are tracked: generation complete, deterministic self-test fault and entropy health fault. An interrupt-control write port sets a per-flag enable and can clear flags with self-clearing clear bits. The enabled flags are OR-ed into a core interrupt, which is bit 0 of a two-bit top-level interrupt status set. Bit 1 of that set is a bus slave error flag. The top-level set has a mask with separate mask-clear and mask-set write ports.

Fault events from an injection port only reach the flags while the entropy source is running. That means the block is out of reset, the source is enabled and the oscillator is on. For the health fault, hardware versions older than 0x0200 also need an explicit health-test enable.

The interrupt line is driven by a two-state machine. In `IRQ_QUIET` the line is low; it moves to `IRQ_RAISED` when an unmasked status bit will be set after the edge. In `IRQ_RAISED` the line is high; it returns to `IRQ_QUIET` when no unmasked bit will remain set. Both transitions are taken on the same edge that updates the status registers.

Top module: `rng_irq_status`

## Requirements
- R1: After reset, `status_o` is 0, `int_en_o` is 0, `isr_o` is 0, `imr_o` is 2'b11 and `irq_o` is 0.
- R2: `done_evt` sets status bit 0 on the next edge, and the bit stays set until it is cleared. Status bit 2 always reads 0.
- R3: A write to `ictl_we` loads `ictl_wdata[2:0]` as the enables for done, deterministic fault and health fault. Writing 1 to `ictl_wdata` bits 3, 4 or 5 clears status bit 0, 1 or 3 respectively. These clear bits are not stored. If a set event and a clear reach the same flag in the same cycle, the flag ends up set.
- R4: `fault_evt[1]` sets status bit 1 and `fault_evt[3]` sets status bit 3. Both are ignored while `blk_in_reset` is high, `src_en` is low or `osc_en` is low.
- R5: When `hw_version` is below 0x0200, `fault_evt[3]` is also ignored while `hlth_en` is low. From 0x0200 upward, `hlth_en` has no effect.
- R6: Whenever an edge changes a status flag or an enable, `isr_o[0]` becomes the OR of each new flag AND-ed with its new enable. On an edge with no such change, writing 1 to `isr_wdata[0]` clears `isr_o[0]`.
- R7: `slverr_evt` sets `isr_o[1]`, and writing 1 to `isr_wdata[1]` clears it. If both happen in the same cycle, the event wins.
- R8: Writing `ier_wdata` clears the matching `imr_o` bits. Writing `idr_wdata` sets them. If both write the same bit in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when some `isr_o` bit is set whose `imr_o` bit is clear. It updates on the same edge as `isr_o` and `imr_o`.
- R10: `soft_rst` clears all status flags and `isr_o[0]` on the next edge. It overrides events and clear writes in that cycle, and it leaves the enables and the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Soft reset of the status flags and the core interrupt |
| done_evt | input | 1 | Generation-complete event |
| fault_evt | input | 4 | Fault injection; bit 1 is the deterministic fault, bit 3 the health fault |
| slverr_evt | input | 1 | Slave error event for `isr_o[1]` |
| blk_in_reset | input | 1 | The core is held in reset |
| src_en | input | 1 | Entropy source enable |
| osc_en | input | 1 | Oscillator enable |
| hlth_en | input | 1 | Health-test enable, needed by older versions |
| hw_version | input | 16 | Hardware version code |
| ictl_we | input | 1 | Interrupt-control write strobe |
| ictl_wdata | input | 6 | Enables in bits 2:0, clear bits in bits 5:3 |
| isr_we | input | 1 | Top-level status write-1-to-clear strobe |
| isr_wdata | input | 2 | Bits to clear |
| ier_we | input | 1 | Mask-clear write strobe |
| ier_wdata | input | 2 | Mask bits to clear |
| idr_we | input | 1 | Mask-set write strobe |
| idr_wdata | input | 2 | Mask bits to set |
| status_o | output | 4 | Flags: bit 0 done, bit 1 deterministic fault, bit 3 health fault |
| int_en_o | output | 3 | Flag enables |
| isr_o | output | 2 | Top-level status: bit 0 core interrupt, bit 1 slave error |
| imr_o | output | 2 | Top-level mask |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that reset is applied before the first checked edge. They also assume that every input is a stable, known value at each rising edge, with each write strobe and its data sampled together as one write. The block places no limit on how write strobes combine, so the stimulus drives all strobes, events and gate inputs independently each cycle. This includes same-cycle clear-versus-set, mask-clear-versus-mask-set, and soft reset together with everything else. It also switches among versions just below, at and above the 0x0200 boundary.

// File: rtl/rng_irq_pkg.sv
package rng_irq_pkg;
    localparam int ST_W    = 4;
    localparam int DONE_B  = 0;
    localparam int DTF_B   = 1;
    localparam int CERTF_B = 3;
    localparam int NFLAG   = 3;
    localparam int ICTL_W  = 2 * NFLAG;
    localparam int ISR_W   = 2;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    // Flag index k (0 done, 1 deterministic, 2 health) to status bit position
    function automatic int flag_pos(input int k);
        return (k == 0) ? DONE_B : ((k == 1) ? DTF_B : CERTF_B);
    endfunction
endpackage

// File: rtl/rng_fault_gate.sv
module rng_fault_gate
    import rng_irq_pkg::*;
#(
    parameter int          VER_W   = 16,
    parameter int unsigned MIN_VER = 32'h0200
) (
    input  logic             blk_in_reset,
    input  logic             src_en,
    input  logic             osc_en,
    input  logic             hlth_en,
    input  logic [VER_W-1:0] hw_version,
    input  logic [ST_W-1:0]  fault_evt,
    output logic             dtf_set,
    output logic             certf_set
);
    localparam logic [VER_W-1:0] MIN_V = VER_W'(MIN_VER);

    logic source_live;
    logic health_ok;
    logic unused_evt_bits;

    assign unused_evt_bits = ^{fault_evt[DONE_B], fault_evt[2]};

    always_comb begin
        source_live = !blk_in_reset && src_en && osc_en;
        health_ok   = source_live && ((hw_version >= MIN_V) || hlth_en);
        dtf_set     = source_live && fault_evt[DTF_B];
        certf_set   = health_ok && fault_evt[CERTF_B];
    end
endmodule

// File: rtl/rng_status_bits.sv
module rng_status_bits
    import rng_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              done_evt,
    input  logic              dtf_set,
    input  logic              certf_set,
    input  logic              ictl_we,
    input  logic [ICTL_W-1:0] ictl_wdata,
    output logic [ST_W-1:0]   status,
    output logic [NFLAG-1:0]  int_en,
    output logic              core_next,
    output logic              core_chg
);
    logic [NFLAG-1:0] flg_q, flg_d;
    logic [NFLAG-1:0] en_q, en_d;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;

    assign set_v = {certf_set, dtf_set, done_evt};
    assign clr_v = ictl_we ? ictl_wdata[ICTL_W-1:NFLAG] : '0;

    generate
        for (genvar k = 0; k < NFLAG; k++) begin : g_flag
            always_comb begin
                if (soft_rst)
                    flg_d[k] = 1'b0;
                else if (set_v[k])
                    flg_d[k] = 1'b1;
                else if (clr_v[k])
                    flg_d[k] = 1'b0;
                else
                    flg_d[k] = flg_q[k];
            end
        end
    endgenerate

    always_comb begin
        en_d      = ictl_we ? ictl_wdata[NFLAG-1:0] : en_q;
        core_next = |(flg_d & en_d);
        core_chg  = (flg_d != flg_q) || (en_d != en_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
            en_q  <= '0;
        end else begin
            flg_q <= flg_d;
            en_q  <= en_d;
        end
    end

    always_comb begin
        status = '0;
        for (int k = 0; k < NFLAG; k++)
            status[flag_pos(k)] = flg_q[k];
    end

    assign int_en = en_q;
endmodule

// File: rtl/rng_irq_ctrl.sv
module rng_irq_ctrl
    import rng_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             core_next,
    input  logic             core_chg,
    input  logic             slverr_evt,
    input  logic             isr_we,
    input  logic [ISR_W-1:0] isr_wdata,
    input  logic             ier_we,
    input  logic [ISR_W-1:0] ier_wdata,
    input  logic             idr_we,
    input  logic [ISR_W-1:0] idr_wdata,
    output logic [ISR_W-1:0] isr,
    output logic [ISR_W-1:0] imr,
    output logic             irq
);
    logic [ISR_W-1:0] isr_q, isr_d;
    logic [ISR_W-1:0] imr_q, imr_d;
    logic [ISR_W-1:0] w1c;
    logic             pend_d;
    irq_state_e       st_q, st_d;

    assign w1c = isr_we ? isr_wdata : '0;

    always_comb begin
        if (soft_rst)
            isr_d[0] = 1'b0;
        else if (core_chg)
            isr_d[0] = core_next;
        else if (w1c[0])
            isr_d[0] = 1'b0;
        else
            isr_d[0] = isr_q[0];

        if (slverr_evt)
            isr_d[1] = 1'b1;
        else if (w1c[1])
            isr_d[1] = 1'b0;
        else
            isr_d[1] = isr_q[1];

        imr_d  = (imr_q & ~(ier_we ? ier_wdata : '0)) | (idr_we ? idr_wdata : '0);
        pend_d = |(isr_d & ~imr_d);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_QUIET:  if (pend_d)  st_d = IRQ_RAISED;
            IRQ_RAISED: if (!pend_d) st_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q <= '0;
            imr_q <= '1;
            st_q  <= IRQ_QUIET;
        end else begin
            isr_q <= isr_d;
            imr_q <= imr_d;
            st_q  <= st_d;
        end
    end

    always_comb begin
        irq = (st_q == IRQ_RAISED);
        isr = isr_q;
        imr = imr_q;
    end
endmodule

// File: rtl/rng_irq_status.sv
module rng_irq_status
    import rng_irq_pkg::*;
#(
    parameter int          VER_W   = 16,
    parameter int unsigned MIN_VER = 32'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              done_evt,
    input  logic [ST_W-1:0]   fault_evt,
    input  logic              slverr_evt,
    input  logic              blk_in_reset,
    input  logic              src_en,
    input  logic              osc_en,
    input  logic              hlth_en,
    input  logic [VER_W-1:0]  hw_version,
    input  logic              ictl_we,
    input  logic [ICTL_W-1:0] ictl_wdata,
    input  logic              isr_we,
    input  logic [ISR_W-1:0]  isr_wdata,
    input  logic              ier_we,
    input  logic [ISR_W-1:0]  ier_wdata,
    input  logic              idr_we,
    input  logic [ISR_W-1:0]  idr_wdata,
    output logic [ST_W-1:0]   status_o,
    output logic [NFLAG-1:0]  int_en_o,
    output logic [ISR_W-1:0]  isr_o,
    output logic [ISR_W-1:0]  imr_o,
    output logic              irq_o
);
    logic dtf_set;
    logic certf_set;
    logic core_next;
    logic core_chg;

    rng_fault_gate #(.VER_W(VER_W), .MIN_VER(MIN_VER)) u_gate (
        .blk_in_reset (blk_in_reset),
        .src_en       (src_en),
        .osc_en       (osc_en),
        .hlth_en      (hlth_en),
        .hw_version   (hw_version),
        .fault_evt    (fault_evt),
        .dtf_set      (dtf_set),
        .certf_set    (certf_set)
    );

    rng_status_bits u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .done_evt   (done_evt),
        .dtf_set    (dtf_set),
        .certf_set  (certf_set),
        .ictl_we    (ictl_we),
        .ictl_wdata (ictl_wdata),
        .status     (status_o),
        .int_en     (int_en_o),
        .core_next  (core_next),
        .core_chg   (core_chg)
    );

    rng_irq_ctrl u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .core_next  (core_next),
        .core_chg   (core_chg),
        .slverr_evt (slverr_evt),
        .isr_we     (isr_we),
        .isr_wdata  (isr_wdata),
        .ier_we     (ier_we),
        .ier_wdata  (ier_wdata),
        .idr_we     (idr_we),
        .idr_wdata  (idr_wdata),
        .isr        (isr_o),
        .imr        (imr_o),
        .irq        (irq_o)
    );
endmodule

// File: rtl/rng_irq_status_chk.sv
module rng_irq_status_chk
    import rng_irq_pkg::*;
#(
    parameter int          VER_W   = 16,
    parameter int unsigned MIN_VER = 32'h0200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              done_evt,
    input logic              slverr_evt,
    input logic              blk_in_reset,
    input logic              src_en,
    input logic              osc_en,
    input logic              hlth_en,
    input logic [VER_W-1:0]  hw_version,
    input logic              ier_we,
    input logic [ISR_W-1:0]  ier_wdata,
    input logic              idr_we,
    input logic [ISR_W-1:0]  idr_wdata,
    input logic [ST_W-1:0]   status_o,
    input logic [ISR_W-1:0]  isr_o,
    input logic [ISR_W-1:0]  imr_o,
    input logic              irq_o
);
    localparam logic [VER_W-1:0] MIN_V = VER_W'(MIN_VER);

    // R2
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && !soft_rst) |=> status_o[DONE_B]);

    // R2
    gap_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[2] == 1'b0);

    // R4
    gated_dtf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_in_reset || !src_en || !osc_en) |=> !$rose(status_o[DTF_B]));

    // R5
    old_ver_certf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_version < MIN_V) && !hlth_en) |=> !$rose(status_o[CERTF_B]));

    // R7
    slverr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slverr_evt |=> isr_o[1]);

    // R8
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_we && !idr_we) |=> ((imr_o & $past(ier_wdata)) == '0));

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idr_we |=> ((imr_o & $past(idr_wdata)) == $past(idr_wdata)));

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(isr_o & ~imr_o));

    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status_o == '0 && !isr_o[0]));
endmodule

bind rng_irq_status rng_irq_status_chk #(.VER_W(VER_W), .MIN_VER(MIN_VER)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .done_evt     (done_evt),
    .slverr_evt   (slverr_evt),
    .blk_in_reset (blk_in_reset),
    .src_en       (src_en),
    .osc_en       (osc_en),
    .hlth_en      (hlth_en),
    .hw_version   (hw_version),
    .ier_we       (ier_we),
    .ier_wdata    (ier_wdata),
    .idr_we       (idr_we),
    .idr_wdata    (idr_wdata),
    .status_o     (status_o),
    .isr_o        (isr_o),
    .imr_o        (imr_o),
    .irq_o        (irq_o)
);

// File: tb/sim_rng_irq_status.sv
module sim_rng_irq_status;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        soft_rst;
    logic        done_evt;
    logic [3:0]  fault_evt;
    logic        slverr_evt;
    logic        blk_in_reset;
    logic        src_en;
    logic        osc_en;
    logic        hlth_en;
    logic [15:0] hw_version;
    logic        ictl_we;
    logic [5:0]  ictl_wdata;
    logic        isr_we;
    logic [1:0]  isr_wdata;
    logic        ier_we;
    logic [1:0]  ier_wdata;
    logic        idr_we;
    logic [1:0]  idr_wdata;
    logic [3:0]  status_o;
    logic [2:0]  int_en_o;
    logic [1:0]  isr_o;
    logic [1:0]  imr_o;
    logic        irq_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rng_irq_status u0 (.*);

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    // bench reference state
    logic [2:0] m_flg;
    logic [2:0] m_en;
    logic [1:0] m_isr;
    logic [1:0] m_imr;

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] flags_to_status(input logic [2:0] f);
        return {f[2], 1'b0, f[1], f[0]};
    endfunction

    task automatic idle_inputs();
        soft_rst = 0; done_evt = 0; fault_evt = 0; slverr_evt = 0;
        ictl_we = 0; ictl_wdata = 0; isr_we = 0; isr_wdata = 0;
        ier_we = 0; ier_wdata = 0; idr_we = 0; idr_wdata = 0;
    endtask

    // Advance one edge with the inputs as driven; update the reference model.
    task automatic tick();
        logic       live, hok, chg;
        logic [2:0] setv, clrv, nf, ne;
        logic [1:0] ni, nm;
        live = !blk_in_reset && src_en && osc_en;
        hok  = live && ((hw_version >= 16'h0200) || hlth_en);
        setv = {fault_evt[3] && hok, fault_evt[1] && live, done_evt};
        clrv = ictl_we ? ictl_wdata[5:3] : 3'b000;
        for (int k = 0; k < 3; k++)
            nf[k] = soft_rst ? 1'b0 : (setv[k] ? 1'b1 : (clrv[k] ? 1'b0 : m_flg[k]));
        ne  = ictl_we ? ictl_wdata[2:0] : m_en;
        chg = (nf != m_flg) || (ne != m_en);
        ni[0] = soft_rst ? 1'b0 : (chg ? |(nf & ne) : ((isr_we && isr_wdata[0]) ? 1'b0 : m_isr[0]));
        ni[1] = slverr_evt ? 1'b1 : ((isr_we && isr_wdata[1]) ? 1'b0 : m_isr[1]);
        nm = (m_imr & ~(ier_we ? ier_wdata : 2'b00)) | (idr_we ? idr_wdata : 2'b00);
        @(posedge clk);
        #1;
        m_flg = nf; m_en = ne; m_isr = ni; m_imr = nm;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic compare_all();
        chk("R4", "status", {4'b0, status_o}, {4'b0, flags_to_status(m_flg)});
        chk("R3", "enables", {5'b0, int_en_o}, {5'b0, m_en});
        chk("R6", "isr", {6'b0, isr_o}, {6'b0, m_isr});
        chk("R8", "imr", {6'b0, imr_o}, {6'b0, m_imr});
        chk("R9", "irq", {7'b0, irq_o}, {7'b0, |(m_isr & ~m_imr)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        idle_inputs();
        blk_in_reset = 0; src_en = 1; osc_en = 1; hlth_en = 0; hw_version = 16'h0200;
        rst_n = 0;
        m_flg = 0; m_en = 0; m_isr = 0; m_imr = 2'b11;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "status", {4'b0, status_o}, 8'h00);
        chk("R1", "enables", {5'b0, int_en_o}, 8'h00);
        chk("R1", "isr", {6'b0, isr_o}, 8'h00);
        chk("R1", "imr", {6'b0, imr_o}, 8'h03);
        chk("R1", "irq", {7'b0, irq_o}, 8'h00);

        // R2 done sets and sticks; bit 2 stays zero
        done_evt = 1; tick();
        chk("R2", "done set", {4'b0, status_o}, 8'h01);
        tick(); tick();
        chk("R2", "done sticky", {4'b0, status_o}, 8'h01);

        // R3 clear plus set in the same cycle: set wins
        done_evt = 1; ictl_we = 1; ictl_wdata = 6'b001_000; tick();
        chk("R3", "set beats clear", {4'b0, status_o}, 8'h01);
        ictl_we = 1; ictl_wdata = 6'b001_001; tick();
        chk("R3", "clear, enable done", {4'b0, status_o}, 8'h00);
        chk("R3", "enables loaded", {5'b0, int_en_o}, 8'h01);

        // R4 gate: oscillator off blocks deterministic fault
        osc_en = 0; fault_evt = 4'b1010; tick();
        chk("R4", "osc off ignored", {4'b0, status_o}, 8'h00);
        osc_en = 1; blk_in_reset = 1; fault_evt = 4'b1010; tick();
        chk("R4", "in reset ignored", {4'b0, status_o}, 8'h00);
        blk_in_reset = 0; src_en = 0; fault_evt = 4'b1010; tick();
        chk("R4", "source off ignored", {4'b0, status_o}, 8'h00);
        src_en = 1; fault_evt = 4'b0010; tick();
        chk("R4", "dtf set", {4'b0, status_o}, 8'h02);

        // R5 version gate on health fault
        hw_version = 16'h01ff; hlth_en = 0; fault_evt = 4'b1000; tick();
        chk("R5", "old ver no hlth", {4'b0, status_o}, 8'h02);
        hlth_en = 1; fault_evt = 4'b1000; tick();
        chk("R5", "old ver with hlth", {4'b0, status_o}, 8'h0a);
        ictl_we = 1; ictl_wdata = 6'b100_001; tick();
        hw_version = 16'h0200; hlth_en = 0; fault_evt = 4'b1000; tick();
        chk("R5", "new ver ignores hlth", {4'b0, status_o}, 8'h0a);

        // R6 core interrupt and its W1C
        ictl_we = 1; ictl_wdata = 6'b000_010; tick();
        chk("R6", "core int from dtf", {6'b0, isr_o}, 8'h01);
        isr_we = 1; isr_wdata = 2'b01; tick();
        chk("R6", "w1c clears core", {6'b0, isr_o}, 8'h00);
        chk("R6", "status kept", {4'b0, status_o}, 8'h0a);

        // R8 and R9: unmask, irq rises; both ports same bit -> set wins
        done_evt = 1; ictl_we = 1; ictl_wdata = 6'b000_011; tick();
        ier_we = 1; ier_wdata = 2'b01; tick();
        chk("R9", "irq after unmask", {7'b0, irq_o}, 8'h01);
        ier_we = 1; ier_wdata = 2'b01; idr_we = 1; idr_wdata = 2'b01; tick();
        chk("R8", "mask-set wins", {6'b0, imr_o}, 8'h03);
        chk("R9", "irq masked", {7'b0, irq_o}, 8'h00);

        // R7 slave error with simultaneous clear
        ier_we = 1; ier_wdata = 2'b10; slverr_evt = 1; isr_we = 1; isr_wdata = 2'b10; tick();
        chk("R7", "event beats w1c", {6'b0, isr_o}, 8'h03);
        chk("R9", "irq from slverr", {7'b0, irq_o}, 8'h01);
        isr_we = 1; isr_wdata = 2'b10; tick();
        chk("R7", "slverr cleared", {6'b0, isr_o}, 8'h01);

        // R10 soft reset beats an event, keeps enables and mask
        soft_rst = 1; done_evt = 1; fault_evt = 4'b1010; tick();
        chk("R10", "status cleared", {4'b0, status_o}, 8'h00);
        chk("R10", "core cleared", {6'b0, isr_o}, 8'h00);
        chk("R10", "enables kept", {5'b0, int_en_o}, 8'h03);
        chk("R10", "mask kept", {6'b0, imr_o}, 8'h01);

        // Random phase against the reference model
        for (int i = 0; i < 3000; i++) begin
            done_evt     = ($urandom % 8) == 0;
            fault_evt    = (($urandom % 4) == 0) ? 4'($urandom) : 4'b0;
            slverr_evt   = ($urandom % 12) == 0;
            blk_in_reset = ($urandom % 6) == 0;
            src_en       = ($urandom % 5) != 0;
            osc_en       = ($urandom % 5) != 0;
            hlth_en      = ($urandom % 2) == 0;
            case ($urandom % 4)
                0: hw_version = 16'h0100;
                1: hw_version = 16'h01ff;
                2: hw_version = 16'h0200;
                default: hw_version = 16'h0300;
            endcase
            ictl_we    = ($urandom % 4) == 0;
            ictl_wdata = 6'($urandom);
            isr_we     = ($urandom % 4) == 0;
            isr_wdata  = 2'($urandom);
            ier_we     = ($urandom % 6) == 0;
            ier_wdata  = 2'($urandom);
            idr_we     = ($urandom % 6) == 0;
            idr_wdata  = 2'($urandom);
            soft_rst   = ($urandom % 40) == 0;
            tick();
            compare_all();
            if (status_o[2] !== 1'b0) chk("R2", "gap bit", {4'b0, status_o}, {4'b0, status_o & 4'b1011});
        end

        done_flag = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule